// File: doc/BRIEF.md
# Open-Drain Pin-Pair Control Register

This block holds the control state for a pair of open-drain pins, one used as a serial clock line and one as a serial data line. Software uses it to drive an I2C-style bus by hand, one bit at a time. The host sees a single 32-bit word. Each pin owns a byte-wide field with these parts:

- a direction bit;
- an output-value bit;
- a write-enable mask for the direction bit;
- a write-enable mask for the value bit;
- a synchronised input sample;
- a pull-up disable bit.

A direction or value bit changes only when its own mask bit is 1 in the same write. Software can therefore release a line or pull it low with one write and leave the other latch alone. The pad never drives high. Its output enable is asserted only when the pin is an output with value 0. The line level models an external pull-up, wired-AND with an external device that may also pull the line low.

Bit positions in the word (pin 0 = clock at base 0, pin 1 = data at base 8):

| Bit | Field |
|-----|-------|
| base+0 | direction (1 = output) |
| base+1 | direction mask |
| base+2 | output value |
| base+3 | value mask |
| base+4 | input sample (read only) |
| base+5 | pull-up disable |

All other bits read as 0.

Top module: `gpio_pad_reg`

## Requirements
- R1: A write with direction mask = 1 and direction = 0 releases that pin: its output enable is 0 after the write edge, and with no external pull the line is high.
- R2: A write with direction = 1, value = 0 and both masks = 1 drives that pin: its output enable is 1 and its line is low after the write edge.
- R3: A write whose direction mask is 0 leaves that pin's direction unchanged. A write whose value mask is 0 leaves that pin's value unchanged. In particular, a write with both masks 0 changes neither the output enable nor the read-back direction and value bits.
- R4: The input bit (base+4) reads the live line level whatever the direction, including a line held low by an external device while the pin is an input, and a line held low externally while the pin is an output with value 1.
- R5: The pad is never driven high. Output enable equals (direction = 1 AND value = 0), so direction = 1 with value = 1 leaves the line to the pull-up.
- R6: The pull-up disable bits (base+5) are plain read/write state, loaded on every write with no mask. They appear on the `puDis` outputs and in read-back, and a write with the bit at 0 clears them.
- R7: Mask bits and unused bits always read 0. Writing the input-bit position has no effect on read-back.
- R8: The input bit passes through a two-flop synchroniser. A line change made between edges is not visible after one clock edge and is visible after the second edge.
- R9: During and after reset both pins are inputs with value 0 and pull-ups enabled. Output enables and `puDis` are 0, and once the synchroniser has filled the read-back word is 0x1010 with no external pull.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wEn | input | 1 | Host write strobe, one cycle per write |
| wData | input | 32 | Host write word |
| rData | output | 32 | Host read word (combinational from state) |
| extLow | input | 2 | External device pulling each line low (bit 0 clock, bit 1 data) |
| padOe | output | 2 | Pad pull-down enable per pin |
| padLevel | output | 2 | Resolved line level per pin with the external pull-up |
| puDis | output | 2 | Pull-up disable per pin |

## Verification
The block's outputs become valid at different times after a write:

- Direction, value and pull-up state load on the write edge.
- `padOe`, `padLevel`, `puDis` and the state fields of `rData` follow combinationally in the same cycle.
- The input bits in `rData` trail the line level by exactly two edges, because of the synchroniser.

The bench applies each write at a falling edge and checks the pad outputs at the next falling edge. It checks the full read word only after three further edges, so the synchroniser has settled. The synchroniser case is checked separately, at the falling edges after the first and after the second rising edge that follow an external line change.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
  localparam int REG_W      = 32;
  localparam int PIN_CNT    = 2;
  localparam int PIN_STRIDE = 8;
  localparam int OFF_DIR    = 0;
  localparam int OFF_DIR_MK = 1;
  localparam int OFF_VAL    = 2;
  localparam int OFF_VAL_MK = 3;
  localparam int OFF_IN     = 4;
  localparam int OFF_PU_DIS = 5;

  // strobes and new field values from the write decoder to the datapath
  typedef struct packed {
    logic [PIN_CNT-1:0] dirLd;
    logic [PIN_CNT-1:0] dirNew;
    logic [PIN_CNT-1:0] valLd;
    logic [PIN_CNT-1:0] valNew;
    logic               puLd;
    logic [PIN_CNT-1:0] puNew;
  } padStrobe_t;
endpackage

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pad_pkg::*;
(
  input  logic             wEn,
  input  logic [REG_W-1:0] wData,
  output padStrobe_t       strobe
);
  logic unusedWData;
  assign unusedWData = ^wData;

  generate
    for (genvar p = 0; p < PIN_CNT; p++) begin : g_pin
      localparam int BASE = p * PIN_STRIDE;
      assign strobe.dirLd[p]  = wEn & wData[BASE + OFF_DIR_MK];
      assign strobe.dirNew[p] = wData[BASE + OFF_DIR];
      assign strobe.valLd[p]  = wEn & wData[BASE + OFF_VAL_MK];
      assign strobe.valNew[p] = wData[BASE + OFF_VAL];
      assign strobe.puNew[p]  = wData[BASE + OFF_PU_DIS];
    end
  endgenerate

  // pull-up disable bits have no mask: every write loads them
  assign strobe.puLd = wEn;
endmodule

// File: rtl/gpio_pad_dp.sv
module gpio_pad_dp
  import gpio_pad_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  padStrobe_t         strobe,
  input  logic [PIN_CNT-1:0] extLow,
  output logic [PIN_CNT-1:0] padOe,
  output logic [PIN_CNT-1:0] padLevel,
  output logic [PIN_CNT-1:0] puDis,
  output logic [REG_W-1:0]   rData
);
  localparam int CNT_W = $clog2(SYNC_STAGES + 1);

  logic [PIN_CNT-1:0] dirQ;
  logic [PIN_CNT-1:0] valQ;
  logic [PIN_CNT-1:0] puQ;
  logic [PIN_CNT-1:0] syncQ [SYNC_STAGES];
  logic [CNT_W-1:0]   settleCnt;

  generate
    for (genvar p = 0; p < PIN_CNT; p++) begin : g_pin
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          dirQ[p] <= 1'b0;
          valQ[p] <= 1'b0;
        end else begin
          if (strobe.dirLd[p]) dirQ[p] <= strobe.dirNew[p];
          if (strobe.valLd[p]) valQ[p] <= strobe.valNew[p];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            puQ <= '0;
    else if (strobe.puLd) puQ <= strobe.puNew;
  end

  // open drain: only ever pull low
  assign padOe    = dirQ & ~valQ;
  assign padLevel = ~(padOe | extLow);
  assign puDis    = puQ;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)       syncQ[s] <= '0;
        else if (s == 0) syncQ[s] <= padLevel;
        else             syncQ[s] <= syncQ[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                settleCnt <= '0;
    else if (settleCnt != CNT_W'(SYNC_STAGES)) settleCnt <= settleCnt + 1'b1;
  end

  always_comb begin
    rData = '0;
    for (int p = 0; p < PIN_CNT; p++) begin
      rData[p*PIN_STRIDE + OFF_DIR]    = dirQ[p];
      rData[p*PIN_STRIDE + OFF_VAL]    = valQ[p];
      rData[p*PIN_STRIDE + OFF_IN]     = syncQ[SYNC_STAGES-1][p];
      rData[p*PIN_STRIDE + OFF_PU_DIS] = puQ[p];
    end
  end

  generate
    if (SYNC_STAGES == 2) begin : g_sync_chk
      for (genvar p = 0; p < PIN_CNT; p++) begin : g_pin_chk
        AST_SYNC_TWO_FLOP: assert property (@(posedge clk) disable iff (!rstN)
          (settleCnt == CNT_W'(SYNC_STAGES)) |-> (rData[p*PIN_STRIDE + OFF_IN] == $past(padLevel[p], 2))); // R8
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_pad_reg.sv
module gpio_pad_reg
  import gpio_pad_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wEn,
  input  logic [REG_W-1:0]   wData,
  output logic [REG_W-1:0]   rData,
  input  logic [PIN_CNT-1:0] extLow,
  output logic [PIN_CNT-1:0] padOe,
  output logic [PIN_CNT-1:0] padLevel,
  output logic [PIN_CNT-1:0] puDis
);
  padStrobe_t strobe;

  gpio_pad_ctrl u_ctrl (
    .wEn    (wEn),
    .wData  (wData),
    .strobe (strobe)
  );

  gpio_pad_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .extLow   (extLow),
    .padOe    (padOe),
    .padLevel (padLevel),
    .puDis    (puDis),
    .rData    (rData)
  );

  generate
    for (genvar p = 0; p < PIN_CNT; p++) begin : g_chk
      localparam int B = p * PIN_STRIDE;
      AST_RELEASE_LINE: assert property (@(posedge clk) disable iff (!rstN)
        (wEn && wData[B+OFF_DIR_MK] && !wData[B+OFF_DIR]) |=> !padOe[p]); // R1
      AST_DRIVE_LOW: assert property (@(posedge clk) disable iff (!rstN)
        (wEn && wData[B+OFF_DIR_MK] && wData[B+OFF_DIR] && wData[B+OFF_VAL_MK] && !wData[B+OFF_VAL])
        |=> (padOe[p] && !padLevel[p])); // R2
      AST_HOLD_UNMASKED: assert property (@(posedge clk) disable iff (!rstN)
        (!wEn || (!wData[B+OFF_DIR_MK] && !wData[B+OFF_VAL_MK])) |=> (padOe[p] == $past(padOe[p]))); // R3
      AST_NEVER_DRIVE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
        (wEn && wData[B+OFF_VAL_MK] && wData[B+OFF_VAL]) |=> !padOe[p]); // R5
      AST_PULLUP_RW: assert property (@(posedge clk) disable iff (!rstN)
        wEn |=> (puDis[p] == $past(wData[B+OFF_PU_DIS]))); // R6
      AST_MASK_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
        (!rData[B+OFF_DIR_MK] && !rData[B+OFF_VAL_MK])); // R7
    end
  endgenerate
endmodule

// File: tb/sim_gpio_pad_reg.sv
`timescale 1ns/1ps
module sim_gpio_pad_reg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wEn = 1'b0;
  logic [31:0] wData = '0;
  logic [31:0] rData;
  logic [1:0]  extLow = '0;
  logic [1:0]  padOe, padLevel, puDis;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gpio_pad_reg u0 (
    .clk(clk), .rstN(rstN), .wEn(wEn), .wData(wData), .rData(rData),
    .extLow(extLow), .padOe(padOe), .padLevel(padLevel), .puDis(puDis)
  );

  // {wData, extLow, expOe, expLevel, expRead}
  localparam int NV = 12;
  localparam logic [69:0] VEC [NV] = '{
    {32'h0000_000B, 2'b00, 2'b01, 2'b10, 32'h0000_1001},  // R2 drive clock low
    {32'h0000_0000, 2'b00, 2'b01, 2'b10, 32'h0000_1001},  // R3 no masks, nothing moves
    {32'h0000_0002, 2'b00, 2'b00, 2'b11, 32'h0000_1010},  // R1 release clock
    {32'h0000_0F00, 2'b00, 2'b00, 2'b11, 32'h0000_1510},  // R5 output with value 1 not driven
    {32'h0000_0800, 2'b00, 2'b10, 2'b01, 32'h0000_0110},  // R3 value mask alone
    {32'h0000_0000, 2'b01, 2'b10, 2'b00, 32'h0000_0100},  // R4 external pull on input pin
    {32'h0000_2020, 2'b00, 2'b10, 2'b01, 32'h0000_2130},  // R6 pull-up disables set
    {32'h0000_0000, 2'b00, 2'b10, 2'b01, 32'h0000_0110},  // R6 cleared by next write
    {32'h0000_0200, 2'b00, 2'b00, 2'b11, 32'h0000_1010},  // R1 release data
    {32'h0000_0B0B, 2'b00, 2'b11, 2'b00, 32'h0000_0101},  // R2 both low in one write
    {32'h0000_FFFF, 2'b00, 2'b00, 2'b11, 32'h0000_3535},  // R7 masks and unused read 0
    {32'h0000_0002, 2'b10, 2'b00, 2'b01, 32'h0000_0514}   // R4 external pull on output pin
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [31:0] d, input logic [1:0] ext);
    @(negedge clk);
    wData = d; extLow = ext; wEn = 1'b1;
    @(negedge clk);
    wEn = 1'b0; wData = '0;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual %0d expected 0", 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R9 reset state
    repeat (3) @(negedge clk);
    chk("R9 oe in reset", 32'(padOe), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 oe after reset", 32'(padOe), 32'h0);
    chk("R9 puDis after reset", 32'(puDis), 32'h0);
    chk("R9 state fields", rData & ~32'h1010, 32'h0);
    repeat (2) @(negedge clk);
    chk("R9 settled read", rData, 32'h1010);

    for (int i = 0; i < NV; i++) begin
      doWrite(VEC[i][69:38], VEC[i][37:36]);
      chk($sformatf("vec%0d oe", i), 32'(padOe), 32'(VEC[i][35:34]));
      chk($sformatf("vec%0d level", i), 32'(padLevel), 32'(VEC[i][33:32]));
      chk($sformatf("vec%0d puDis", i), 32'(puDis), 32'({VEC[i][13], VEC[i][5]}));
      repeat (3) @(negedge clk);
      chk($sformatf("vec%0d read", i), rData, VEC[i][31:0]);
    end

    // R8 synchroniser latency: clock pulled low, data freed
    @(negedge clk);
    extLow = 2'b01;
    @(negedge clk);
    chk("R8 clock in after one edge", 32'(rData[4]), 32'h1);
    chk("R8 data in after one edge", 32'(rData[12]), 32'h0);
    @(negedge clk);
    chk("R8 clock in after two edges", 32'(rData[4]), 32'h0);
    chk("R8 data in after two edges", 32'(rData[12]), 32'h1);
    extLow = 2'b00;

    // R9 reset from a driven state
    doWrite(32'h0000_0B0B, 2'b00);
    chk("R9 driven before reset", 32'(padOe), 32'h3);
    rstN = 1'b0;
    #1;
    chk("R9 oe cleared by reset", 32'(padOe), 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 read after re-reset", rData, 32'h1010);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule